// File: doc/BRIEF.md
# Reset Source Controller

This block turns a set of digital fault and supply conditions into the two reset levels of a small microcontroller core. The hard reset (`por_o`) clears everything; the soft reset (`puc_o`) clears only ordinary state. A hard reset can come from the supply not being good yet, from the external reset/interrupt pin held low while it is set up as a reset, or from the supply supervisor reporting a low rail while its reset enable is on. A soft reset comes from any hard reset, from a watchdog expiry in watchdog mode, or from a write to the watchdog or flash control register whose key byte is not 0x5A. Both reset outputs are stretched and released on a clock edge.

The block keeps three sticky cause flags that software reads after restart to find out why the core was reset. It also holds two sample registers that show the two reset classes: one is cleared by every soft reset, and the other is cleared only by a hard reset. The restart address is a fixed vector output.

Top module: `rsc_ctrl`

## Requirements
- R1: `por_o` rises in the cycle after any clock edge that samples `pwr_good_i` low, or `rst_pin_n_i` low with `pin_nmi_mode_i` low, or `svs_low_i` high with `svs_rst_en_i` high.
- R2: A low pin while `pin_nmi_mode_i` is high, and a supervisor low while `svs_rst_en_i` is low, cause neither reset.
- R3: Every cycle in which `por_o` is high also has `puc_o` high.
- R4: `wdt_expire_i` raises `puc_o` when `wdt_intvl_mode_i` is 0 (watchdog mode) and has no effect when it is 1 (interval mode).
- R5: A strobe on `wdt_ctl_wr_i` with `wr_key_i` not equal to 0x5A raises `puc_o` in either watchdog mode; with key 0x5A it causes no reset.
- R6: A strobe on `flash_ctl_wr_i` with `wr_key_i` not equal to 0x5A raises `puc_o` and sets no cause flag.
- R7: Each reset output stays high for exactly 4 cycles after the last edge that sampled its trigger, then falls on a clock edge.
- R8: `cause_o` bit 0 is power-on, bit 1 is pin reset, bit 2 is watchdog timeout or watchdog key violation; power-up (`pwr_good_i` low) loads 3'b001, and pin reset or watchdog events set their bit in the cycle after.
- R9: A soft reset leaves `cause_o` unchanged; a strobe on `flag_wr_i` clears each bit where `flag_data_i` is 0 and keeps bits where it is 1, and a set in the same cycle wins over a clear.
- R10: `reset_vec_o` always reads 0xFFFE.
- R11: `vol_reg_o` returns to its reset value (0) during any soft reset; `keep_reg_o` keeps its value through a soft reset alone and returns to 0 only during a hard reset. `reg_wr_i` bit 0 writes `vol_reg_o`, bit 1 writes `keep_reg_o`, both from `reg_data_i`, visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Supply good; low forces power-on reset |
| rst_pin_n_i | input | 1 | Reset/interrupt pin, active low |
| pin_nmi_mode_i | input | 1 | 1: pin acts as interrupt, 0: pin acts as reset |
| svs_low_i | input | 1 | Supply supervisor reports low rail |
| svs_rst_en_i | input | 1 | Supervisor low may reset the device |
| wdt_expire_i | input | 1 | Watchdog counter expiry pulse |
| wdt_intvl_mode_i | input | 1 | 1: watchdog in interval mode |
| wdt_ctl_wr_i | input | 1 | Write strobe, watchdog control register |
| flash_ctl_wr_i | input | 1 | Write strobe, flash control registers |
| wr_key_i | input | 8 | Upper byte of the control register write |
| flag_wr_i | input | 1 | Write strobe for the cause flags |
| flag_data_i | input | 3 | Cause flag write data (0 clears) |
| reg_wr_i | input | 2 | Sample register write strobes |
| reg_data_i | input | 8 | Sample register write data |
| por_o | output | 1 | Hard reset, stretched |
| puc_o | output | 1 | Soft reset, stretched |
| cause_o | output | 3 | Sticky reset cause flags |
| vol_reg_o | output | 8 | Register cleared on soft reset |
| keep_reg_o | output | 8 | Register cleared on hard reset only |
| reset_vec_o | output | 16 | Restart vector address |

## Verification
A trigger sampled at one edge shows on `por_o`, `puc_o` and `cause_o` one cycle later and the resets stay high through four sampled cycles, falling in the fifth; register writes show one cycle after the strobe, and the sample registers are checked only after the reset pulse has ended. The driver turns each stimulus into expected items stamped with the cycle they fall due, kept in a queue ordered by that cycle, and the monitor compares each item on the falling edge of that exact cycle, so every latency is checked, not just the final value.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_WDT = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_POWERUP = cause_t'(1 << CAUSE_POR);
endpackage

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (trig_i) begin
      cnt_q   <= LOAD;
      pulse_o <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   pwr_up_i,
  input  cause_t set_i,
  input  logic   wr_i,
  input  cause_t wr_data_i,
  output cause_t cause_o
);
  cause_t kept;

  always_comb kept = wr_i ? (cause_o & wr_data_i) : cause_o;

  always_ff @(posedge clk) begin
    if (pwr_up_i) cause_o <= CAUSE_POWERUP;
    else          cause_o <= kept | set_i;
  end
endmodule

// File: rtl/rsc_retreg.sv
module rsc_retreg #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (clr_i)     q_o <= RST;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int                 KEY_W     = 8,
  parameter logic [KEY_W-1:0]   KEY       = 8'h5A,
  parameter int                 STRETCH   = 4,
  parameter int                 REG_W     = 8,
  parameter logic [REG_W-1:0]   VOL_RST   = '0,
  parameter logic [REG_W-1:0]   KEEP_RST  = '0,
  parameter int                 VEC_W     = 16,
  parameter logic [VEC_W-1:0]   RESET_VEC = 16'hFFFE
) (
  input  logic               clk,
  input  logic               pwr_good_i,
  input  logic               rst_pin_n_i,
  input  logic               pin_nmi_mode_i,
  input  logic               svs_low_i,
  input  logic               svs_rst_en_i,
  input  logic               wdt_expire_i,
  input  logic               wdt_intvl_mode_i,
  input  logic               wdt_ctl_wr_i,
  input  logic               flash_ctl_wr_i,
  input  logic [KEY_W-1:0]   wr_key_i,
  input  logic               flag_wr_i,
  input  logic [CAUSE_W-1:0] flag_data_i,
  input  logic [1:0]         reg_wr_i,
  input  logic [REG_W-1:0]   reg_data_i,
  output logic               por_o,
  output logic               puc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [REG_W-1:0]   vol_reg_o,
  output logic [REG_W-1:0]   keep_reg_o,
  output logic [VEC_W-1:0]   reset_vec_o
);
  localparam int NREG = 2;

  logic   pwr_up, pin_rst, svs_rst, por_req;
  logic   wdt_to, wdt_key_bad, fl_key_bad, puc_req;
  cause_t cause_set;

  always_comb begin
    pwr_up      = ~pwr_good_i;
    pin_rst     = ~rst_pin_n_i & ~pin_nmi_mode_i;
    svs_rst     = svs_low_i & svs_rst_en_i;
    por_req     = pwr_up | pin_rst | svs_rst;
    wdt_to      = wdt_expire_i & ~wdt_intvl_mode_i;
    wdt_key_bad = wdt_ctl_wr_i & (wr_key_i != KEY);
    fl_key_bad  = flash_ctl_wr_i & (wr_key_i != KEY);
    puc_req     = por_req | wdt_to | wdt_key_bad | fl_key_bad;
    cause_set            = '0;
    cause_set[CAUSE_PIN] = pin_rst;
    cause_set[CAUSE_WDT] = wdt_to | wdt_key_bad;
  end

  rsc_stretch #(.LEN(STRETCH)) u_por (.clk(clk), .trig_i(por_req), .pulse_o(por_o));
  rsc_stretch #(.LEN(STRETCH)) u_puc (.clk(clk), .trig_i(puc_req), .pulse_o(puc_o));

  rsc_cause u_cause (
    .clk       (clk),
    .pwr_up_i  (pwr_up),
    .set_i     (cause_set),
    .wr_i      (flag_wr_i),
    .wr_data_i (flag_data_i),
    .cause_o   (cause_o)
  );

  // Slot 0 follows the soft reset, slot 1 only the hard reset.
  logic [REG_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] RV = (g == 0) ? VOL_RST : KEEP_RST;
    rsc_retreg #(.W(REG_W), .RST(RV)) u_reg (
      .clk   (clk),
      .clr_i ((g == 0) ? puc_o : por_o),
      .wr_i  (reg_wr_i[g]),
      .d_i   (reg_data_i),
      .q_o   (reg_q[g])
    );
  end

  assign vol_reg_o   = reg_q[0];
  assign keep_reg_o  = reg_q[1];
  assign reset_vec_o = RESET_VEC;
endmodule

// File: rtl/rsc_ctrl_chk.sv
module rsc_ctrl_chk #(
  parameter int               KEY_W     = 8,
  parameter logic [KEY_W-1:0] KEY       = 8'h5A,
  parameter int               STRETCH   = 4,
  parameter int               REG_W     = 8,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'hFFFE
) (
  input logic             clk,
  input logic             pwr_good_i,
  input logic             rst_pin_n_i,
  input logic             pin_nmi_mode_i,
  input logic             wdt_expire_i,
  input logic             wdt_intvl_mode_i,
  input logic             wdt_ctl_wr_i,
  input logic             flash_ctl_wr_i,
  input logic [KEY_W-1:0] wr_key_i,
  input logic             flag_wr_i,
  input logic [1:0]       reg_wr_i,
  input logic             por_o,
  input logic             puc_o,
  input logic [2:0]       cause_o,
  input logic [REG_W-1:0] keep_reg_o,
  input logic [VEC_W-1:0] reset_vec_o
);
  localparam int RUN_W = $clog2(STRETCH + 2);
  logic [RUN_W-1:0] puc_run;

  always_ff @(posedge clk) begin
    if (!puc_o)                          puc_run <= '0;
    else if (puc_run != RUN_W'(STRETCH)) puc_run <= puc_run + 1'b1;
  end

  assert_pin_por_R1: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (!rst_pin_n_i && !pin_nmi_mode_i) |=> por_o);

  assert_por_has_puc_R3: assert property (@(posedge clk) disable iff (!pwr_good_i)
    por_o |-> puc_o);

  assert_wdt_expiry_R4: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (wdt_expire_i && !wdt_intvl_mode_i) |=> puc_o);

  assert_wdt_key_R5: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (wdt_ctl_wr_i && wr_key_i != KEY) |=> puc_o);

  assert_flash_key_R6: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (flash_ctl_wr_i && wr_key_i != KEY) |=> puc_o);

  assert_min_width_R7: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (!puc_o && puc_run != '0) |-> (puc_run >= RUN_W'(STRETCH)));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (puc_o && !flag_wr_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

  assert_vector_R10: assert property (@(posedge clk) disable iff (!pwr_good_i)
    reset_vec_o == RESET_VEC);

  assert_keep_survives_R11: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (puc_o && !por_o && !reg_wr_i[1]) |=> $stable(keep_reg_o));
endmodule

bind rsc_ctrl rsc_ctrl_chk #(
  .KEY_W(KEY_W), .KEY(KEY), .STRETCH(STRETCH), .REG_W(REG_W),
  .VEC_W(VEC_W), .RESET_VEC(RESET_VEC)
) chk_i (
  .clk              (clk),
  .pwr_good_i       (pwr_good_i),
  .rst_pin_n_i      (rst_pin_n_i),
  .pin_nmi_mode_i   (pin_nmi_mode_i),
  .wdt_expire_i     (wdt_expire_i),
  .wdt_intvl_mode_i (wdt_intvl_mode_i),
  .wdt_ctl_wr_i     (wdt_ctl_wr_i),
  .flash_ctl_wr_i   (flash_ctl_wr_i),
  .wr_key_i         (wr_key_i),
  .flag_wr_i        (flag_wr_i),
  .reg_wr_i         (reg_wr_i),
  .por_o            (por_o),
  .puc_o            (puc_o),
  .cause_o          (cause_o),
  .keep_reg_o       (keep_reg_o),
  .reset_vec_o      (reset_vec_o)
);

// File: tb/rsc_ctrl_tb.sv
module rsc_ctrl_tb_top;
  localparam int SEL_POR = 0, SEL_PUC = 1, SEL_CAUSE = 2, SEL_VOL = 3, SEL_KEEP = 4, SEL_VEC = 5;

  typedef struct {
    int          due;
    string       req;
    int          sel;
    logic [15:0] val;
  } item_t;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0, rst_pin_n = 1'b1, nmi_mode = 1'b0;
  logic       svs_low = 1'b0, svs_en = 1'b0;
  logic       wdt_exp = 1'b0, wdt_intvl = 1'b0, wdt_wr = 1'b0, fl_wr = 1'b0;
  logic [7:0] key = 8'h5A;
  logic       flag_wr = 1'b0;
  logic [2:0] flag_data = 3'b111;
  logic [1:0] reg_wr = 2'b00;
  logic [7:0] reg_data = 8'h00;
  logic       por, puc;
  logic [2:0] cause;
  logic [7:0] vol_reg, keep_reg;
  logic [15:0] vec;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rsc_ctrl dut_i (
    .clk(clk), .pwr_good_i(pwr_good), .rst_pin_n_i(rst_pin_n), .pin_nmi_mode_i(nmi_mode),
    .svs_low_i(svs_low), .svs_rst_en_i(svs_en), .wdt_expire_i(wdt_exp),
    .wdt_intvl_mode_i(wdt_intvl), .wdt_ctl_wr_i(wdt_wr), .flash_ctl_wr_i(fl_wr),
    .wr_key_i(key), .flag_wr_i(flag_wr), .flag_data_i(flag_data), .reg_wr_i(reg_wr),
    .reg_data_i(reg_data), .por_o(por), .puc_o(puc), .cause_o(cause),
    .vol_reg_o(vol_reg), .keep_reg_o(keep_reg), .reset_vec_o(vec)
  );

  task automatic expect_at(int d, string r, int s, logic [15:0] v);
    item_t it;
    int i = 0;
    it.due = cyc + d; it.req = r; it.sel = s; it.val = v;
    while (i < sb.size() && sb[i].due <= it.due) i++;
    sb.insert(i, it);
  endtask

  // Trigger driven for one cycle at the current falling edge.
  task automatic expect_pulse(string r, int s);
    expect_at(1, r, s, 16'd1);
    expect_at(4, r, s, 16'd1);
    expect_at(5, r, s, 16'd0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.sel)
        SEL_POR:   act = {15'd0, por};
        SEL_PUC:   act = {15'd0, puc};
        SEL_CAUSE: act = {13'd0, cause};
        SEL_VOL:   act = {8'd0, vol_reg};
        SEL_KEEP:  act = {8'd0, keep_reg};
        default:   act = vec;
      endcase
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h", it.req, it.sel, cyc, act, it.val);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R8 R10 R11: power-up reset state
    pwr_good = 1'b1;
    expect_at(1, "R1", SEL_POR, 16'd1);
    expect_at(3, "R7", SEL_POR, 16'd1);
    expect_at(4, "R7", SEL_POR, 16'd0);
    expect_at(4, "R3", SEL_PUC, 16'd0);
    expect_at(1, "R8", SEL_CAUSE, 16'h1);
    expect_at(4, "R10", SEL_VEC, 16'hFFFE);
    expect_at(4, "R11", SEL_VOL, 16'h0);
    expect_at(4, "R11", SEL_KEEP, 16'h0);
    drain();

    // R11: register writes
    reg_wr = 2'b11; reg_data = 8'hA5;
    expect_at(1, "R11", SEL_VOL, 16'hA5);
    expect_at(1, "R11", SEL_KEEP, 16'hA5);
    @(negedge clk);
    reg_wr = 2'b10; reg_data = 8'h3C;
    expect_at(1, "R11", SEL_KEEP, 16'h3C);
    expect_at(1, "R11", SEL_VOL, 16'hA5);
    @(negedge clk);
    reg_wr = 2'b00;
    drain();

    // R5: bad watchdog key in interval mode
    wdt_intvl = 1'b1; wdt_wr = 1'b1; key = 8'h12;
    expect_pulse("R5", SEL_PUC);
    expect_at(1, "R5", SEL_POR, 16'd0);
    expect_at(1, "R8", SEL_CAUSE, 16'h5);
    expect_at(5, "R9", SEL_CAUSE, 16'h5);
    expect_at(5, "R11", SEL_VOL, 16'h0);
    expect_at(5, "R11", SEL_KEEP, 16'h3C);
    @(negedge clk);
    wdt_wr = 1'b0; key = 8'h5A;
    drain();

    // R5: correct key, no reset
    wdt_wr = 1'b1; key = 8'h5A;
    expect_at(1, "R5", SEL_PUC, 16'd0);
    expect_at(2, "R5", SEL_PUC, 16'd0);
    expect_at(2, "R5", SEL_CAUSE, 16'h5);
    @(negedge clk);
    wdt_wr = 1'b0;
    drain();

    // R6: bad flash key, no flag change
    fl_wr = 1'b1; key = 8'hA5;
    expect_pulse("R6", SEL_PUC);
    expect_at(5, "R6", SEL_CAUSE, 16'h5);
    @(negedge clk);
    fl_wr = 1'b0; key = 8'h5A;
    drain();

    // R4: expiry in interval mode is ignored
    wdt_intvl = 1'b1; wdt_exp = 1'b1;
    expect_at(1, "R4", SEL_PUC, 16'd0);
    expect_at(3, "R4", SEL_PUC, 16'd0);
    @(negedge clk);
    wdt_exp = 1'b0;
    drain();

    // R9: software clears all flags
    flag_wr = 1'b1; flag_data = 3'b000;
    expect_at(1, "R9", SEL_CAUSE, 16'h0);
    @(negedge clk);
    flag_wr = 1'b0; flag_data = 3'b111;
    drain();

    // R4: expiry in watchdog mode
    wdt_intvl = 1'b0; wdt_exp = 1'b1;
    expect_pulse("R4", SEL_PUC);
    expect_at(1, "R8", SEL_CAUSE, 16'h4);
    @(negedge clk);
    wdt_exp = 1'b0;
    drain();

    // R9: writing 1 keeps a bit, writing 0 clears it
    flag_wr = 1'b1; flag_data = 3'b110;
    expect_at(1, "R9", SEL_CAUSE, 16'h4);
    @(negedge clk);
    flag_data = 3'b011;
    expect_at(1, "R9", SEL_CAUSE, 16'h0);
    @(negedge clk);
    flag_wr = 1'b0; flag_data = 3'b111;
    drain();

    // R2: pin low in interrupt mode
    nmi_mode = 1'b1; rst_pin_n = 1'b0;
    expect_at(1, "R2", SEL_POR, 16'd0);
    expect_at(1, "R2", SEL_PUC, 16'd0);
    expect_at(1, "R2", SEL_CAUSE, 16'h0);
    @(negedge clk);
    rst_pin_n = 1'b1; nmi_mode = 1'b0;
    drain();

    // R1 R3 R8 R11: pin reset clears keep register
    reg_wr = 2'b10; reg_data = 8'h3C;
    @(negedge clk);
    reg_wr = 2'b00;
    rst_pin_n = 1'b0;
    expect_pulse("R1", SEL_POR);
    expect_pulse("R3", SEL_PUC);
    expect_at(1, "R8", SEL_CAUSE, 16'h2);
    expect_at(5, "R11", SEL_KEEP, 16'h0);
    @(negedge clk);
    rst_pin_n = 1'b1;
    drain();

    // R2: supervisor low without enable
    svs_low = 1'b1; svs_en = 1'b0;
    expect_at(1, "R2", SEL_POR, 16'd0);
    expect_at(1, "R2", SEL_PUC, 16'd0);
    @(negedge clk);
    svs_en = 1'b1;
    expect_pulse("R1", SEL_POR);
    expect_at(5, "R8", SEL_CAUSE, 16'h2);
    @(negedge clk);
    svs_low = 1'b0; svs_en = 1'b0;
    drain();

    // R7: trigger held three cycles
    rst_pin_n = 1'b0;
    expect_at(6, "R7", SEL_POR, 16'd1);
    expect_at(7, "R7", SEL_POR, 16'd0);
    expect_at(7, "R7", SEL_PUC, 16'd0);
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    drain();

    // R9: set wins over a clear in the same cycle
    flag_wr = 1'b1; flag_data = 3'b000; wdt_exp = 1'b1;
    expect_at(1, "R9", SEL_CAUSE, 16'h4);
    @(negedge clk);
    flag_wr = 1'b0; flag_data = 3'b111; wdt_exp = 1'b0;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule